// File: doc/BRIEF.md
# Dual-Channel Serial Gain Control Register

This block takes a 14-bit control word from a slow serial link made of a data line and a clock line. A separate load strobe then commits the word to one of two channel register banks. The serial clock, serial data and strobe may arrive with no timing relationship to the system clock. All three are brought into the system clock domain through two-flop synchronisers, and their edges are detected there. On each rising edge of the serial clock, one bit moves into a 14-bit shift register, most significant bit (D13) first. On a rising edge of the strobe, the word held at that moment is decoded and written into the bank that bit D7 selects. The other bank is left alone.

Each channel presents a decoded gain as a signed 8-bit dB value beside a mute flag, a three-bit input-enable mask and two 2-bit output-mode selects. The 6-bit gain code maps to mute at zero. Otherwise it maps to a 2 dB-step range that starts at -48 dB and stops at +48 dB; codes above 49 stay at the top value.

Top module: `sgc_top`

## Requirements
- R1: After reset both channels show mute=1, gain 0 dB, input mask 000 and both output modes 00 (high impedance).
- R2: A rising serial clock edge shifts serData in, MSB (D13) first. A strobe commits the last 14 bits shifted, and any earlier extra bits are discarded.
- R3: Shifting alone changes no channel output. A channel's outputs change only after a rising edge of loadStrobe.
- R4: Word bit D7=0 updates channel 1 and D7=1 updates channel 2. The channel that is not addressed keeps all its outputs.
- R5: Gain code (bits D13..D8) 0 gives mute=1 with a dB value of 0.
- R6: Gain codes 1 to 49 give mute=0 and a dB value of 2*code-50, so code 1 is -48, code 25 is 0 and code 49 is +48.
- R7: Gain codes 50 to 63 give mute=0 and +48 dB.
- R8: The input mask port bit 0 follows D4 (input 1), bit 1 follows D5 (input 2) and bit 2 follows D6 (input 3). All eight combinations are legal.
- R9: ModeB follows D1:D0 and ModeA follows D3:D2. The encoding is 00 high impedance, 01 enabled, 10 tied to VSS and 11 tied to bias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, MSB first |
| loadStrobe | input | 1 | Commit strobe, rising edge active |
| ch1GainDb | output | 8 | Channel 1 gain in dB, signed |
| ch1Mute | output | 1 | Channel 1 mute flag |
| ch1InMask | output | 3 | Channel 1 input enables |
| ch1ModeA | output | 2 | Channel 1 mode of outputs 1A and 2 |
| ch1ModeB | output | 2 | Channel 1 mode of output 1B |
| ch2GainDb | output | 8 | Channel 2 gain in dB, signed |
| ch2Mute | output | 1 | Channel 2 mute flag |
| ch2InMask | output | 3 | Channel 2 input enables |
| ch2ModeA | output | 2 | Channel 2 mode of outputs 1A and 2 |
| ch2ModeB | output | 2 | Channel 2 mode of output 1B |

## Verification
On every cycle the assertions check five things. The banks hold still without a commit pulse, and a commit leaves the bank that is not addressed untouched. A muted channel reads 0 dB, and an unmuted gain is always even and lies between -48 and +48. The detected edges last exactly one cycle. Only the bench scenarios can show the exact value of each decode: the position of every field, the MSB-first order and the discarding of extra bits. These depend on comparing a committed word against an independently computed expectation.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int WORD_W        = 14;
  localparam int GAIN_W        = 6;
  localparam int GAIN_LSB      = 8;
  localparam int ADDR_BIT      = 7;
  localparam int MASK_W        = 3;
  localparam int MASK_LSB      = 4;
  localparam int MODE_W        = 2;
  localparam int MODEA_LSB     = 2;
  localparam int MODEB_LSB     = 0;
  localparam int NUM_CH        = 2;
  localparam int DB_W          = 8;
  localparam int GAIN_TOP_CODE = 49;
  localparam int STEP_DB       = 2;
  localparam int FLOOR_DB      = -48;
  localparam int CEIL_DB       = FLOOR_DB + STEP_DB * (GAIN_TOP_CODE - 1);

  typedef enum logic [MODE_W-1:0] {
    OUT_HIZ  = 2'b00,
    OUT_ON   = 2'b01,
    OUT_VSS  = 2'b10,
    OUT_BIAS = 2'b11
  } outMode_t;

  typedef struct packed {
    logic [GAIN_W-1:0] gainCode;
    logic [MASK_W-1:0] inMask;
    outMode_t          modeA;
    outMode_t          modeB;
  } chanCfg_t;

  typedef struct packed {
    logic shiftEn;
    logic latchEn;
  } strobe_t;

  function automatic logic signed [DB_W-1:0] codeToDb(input logic [GAIN_W-1:0] code);
    int v;
    if (code == '0) v = 0;
    else if (code > GAIN_W'(GAIN_TOP_CODE)) v = CEIL_DB;
    else v = FLOOR_DB + STEP_DB * (int'(code) - 1);
    return DB_W'(v);
  endfunction
endpackage

// File: rtl/sgc_sync.sv
module sgc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sgc_ctrl.sv
module sgc_ctrl
  import sgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serData,
  input  logic    loadStrobe,
  output strobe_t strb,
  output logic    dataBit
);
  localparam int N_SIG = 3;

  logic [N_SIG-1:0] rawIn, syncOut;
  logic prevClk, prevStb;

  assign rawIn = {loadStrobe, serClk, serData};

  sgc_sync #(.WIDTH(N_SIG), .STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (rawIn),
    .dout(syncOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      prevStb <= 1'b0;
    end else begin
      prevClk <= syncOut[1];
      prevStb <= syncOut[2];
    end
  end

  assign strb.shiftEn = syncOut[1] & ~prevClk;
  assign strb.latchEn = syncOut[2] & ~prevStb;
  assign dataBit      = syncOut[0];

  AST_SHIFT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> !strb.shiftEn); // R2
  AST_LATCH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchEn |=> !strb.latchEn); // R3
endmodule

// File: rtl/sgc_datapath.sv
module sgc_datapath
  import sgc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strb,
  input  logic                           dataBit,
  output chanCfg_t [NUM_CH-1:0]          cfg,
  output logic signed [NUM_CH-1:0][DB_W-1:0] gainDb,
  output logic [NUM_CH-1:0]              mute
);
  logic [WORD_W-1:0] shiftReg;
  chanCfg_t          newCfg;
  logic              addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], dataBit};
  end

  assign addr            = shiftReg[ADDR_BIT];
  assign newCfg.gainCode = shiftReg[GAIN_LSB +: GAIN_W];
  assign newCfg.inMask   = shiftReg[MASK_LSB +: MASK_W];
  assign newCfg.modeA    = outMode_t'(shiftReg[MODEA_LSB +: MODE_W]);
  assign newCfg.modeB    = outMode_t'(shiftReg[MODEB_LSB +: MODE_W]);

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfg[c] <= '{gainCode: '0, inMask: '0, modeA: OUT_HIZ, modeB: OUT_HIZ};
      else if (strb.latchEn && (addr == 1'(c))) cfg[c] <= newCfg;
    end

    assign mute[c]   = (cfg[c].gainCode == '0);
    assign gainDb[c] = codeToDb(cfg[c].gainCode);

    AST_MUTE_ZERO_DB: assert property (@(posedge clk) disable iff (!rstN)
      mute[c] |-> (gainDb[c] == '0)); // R5
    AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      !mute[c] |-> ($signed(gainDb[c]) >= FLOOR_DB && $signed(gainDb[c]) <= CEIL_DB
                    && !gainDb[c][0])); // R6
    AST_OTHER_HELD: assert property (@(posedge clk) disable iff (!rstN)
      (strb.latchEn && addr != 1'(c)) |=> $stable(cfg[c])); // R4
  end

  AST_NO_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchEn |=> $stable(cfg)); // R3
endmodule

// File: rtl/sgc_top.sv
module sgc_top
  import sgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              loadStrobe,
  output logic signed [7:0] ch1GainDb,
  output logic              ch1Mute,
  output logic [2:0]        ch1InMask,
  output logic [1:0]        ch1ModeA,
  output logic [1:0]        ch1ModeB,
  output logic signed [7:0] ch2GainDb,
  output logic              ch2Mute,
  output logic [2:0]        ch2InMask,
  output logic [1:0]        ch2ModeA,
  output logic [1:0]        ch2ModeB
);
  strobe_t                           strb;
  logic                              dataBit;
  chanCfg_t [NUM_CH-1:0]             cfg;
  logic signed [NUM_CH-1:0][DB_W-1:0] gainDb;
  logic [NUM_CH-1:0]                 mute;

  sgc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .serData   (serData),
    .loadStrobe(loadStrobe),
    .strb      (strb),
    .dataBit   (dataBit)
  );

  sgc_datapath uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dataBit(dataBit),
    .cfg    (cfg),
    .gainDb (gainDb),
    .mute   (mute)
  );

  assign ch1GainDb = gainDb[0];
  assign ch1Mute   = mute[0];
  assign ch1InMask = cfg[0].inMask;
  assign ch1ModeA  = cfg[0].modeA;
  assign ch1ModeB  = cfg[0].modeB;
  assign ch2GainDb = gainDb[1];
  assign ch2Mute   = mute[1];
  assign ch2InMask = cfg[1].inMask;
  assign ch2ModeA  = cfg[1].modeA;
  assign ch2ModeB  = cfg[1].modeB;
endmodule

// File: tb/sim_sgc_top.sv
`timescale 1ns/1ps
module sim_sgc_top;
  logic clk = 1'b0, rstN = 1'b0, serClk = 1'b0, serData = 1'b0, loadStrobe = 1'b0;
  logic signed [7:0] ch1GainDb, ch2GainDb;
  logic ch1Mute, ch2Mute;
  logic [2:0] ch1InMask, ch2InMask;
  logic [1:0] ch1ModeA, ch1ModeB, ch2ModeA, ch2ModeB;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sgc_top u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .loadStrobe(loadStrobe),
    .ch1GainDb(ch1GainDb), .ch1Mute(ch1Mute), .ch1InMask(ch1InMask),
    .ch1ModeA(ch1ModeA), .ch1ModeB(ch1ModeB),
    .ch2GainDb(ch2GainDb), .ch2Mute(ch2Mute), .ch2InMask(ch2InMask),
    .ch2ModeA(ch2ModeA), .ch2ModeB(ch2ModeB)
  );

  function automatic logic [13:0] mkWord(input logic [5:0] code, input logic ch,
                                         input logic [2:0] mask, input logic [1:0] ma,
                                         input logic [1:0] mb);
    return {code, ch, mask, ma, mb};
  endfunction

  function automatic int expDb(input int code);
    if (code == 0) return 0;
    if (code >= 49) return 48;
    return 2 * code - 50;
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    waitClk(4);
    serClk = 1'b1;
    waitClk(4);
    serClk = 1'b0;
  endtask

  task automatic sendWord(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) sendBit(w[i]);
    waitClk(4);
  endtask

  task automatic strobe();
    loadStrobe = 1'b1;
    waitClk(4);
    loadStrobe = 1'b0;
    waitClk(4);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkCh(input int ch, input string req, input int mute, input int db,
                       input int mask, input int ma, input int mb);
    if (ch == 1) begin
      chk(req, "ch1 mute", int'(ch1Mute), mute);
      chk(req, "ch1 dB",   int'(ch1GainDb), db);
      chk(req, "ch1 mask", int'(ch1InMask), mask);
      chk(req, "ch1 modeA", int'(ch1ModeA), ma);
      chk(req, "ch1 modeB", int'(ch1ModeB), mb);
    end else begin
      chk(req, "ch2 mute", int'(ch2Mute), mute);
      chk(req, "ch2 dB",   int'(ch2GainDb), db);
      chk(req, "ch2 mask", int'(ch2InMask), mask);
      chk(req, "ch2 modeA", int'(ch2ModeA), ma);
      chk(req, "ch2 modeB", int'(ch2ModeB), mb);
    end
  endtask

  task automatic tReset();
    chkCh(1, "R1", 1, 0, 0, 0, 0);
    chkCh(2, "R1", 1, 0, 0, 0, 0);
  endtask

  task automatic tShiftOnly();
    sendWord(mkWord(6'd25, 1'b0, 3'b011, 2'b01, 2'b10));
    waitClk(6);
    chkCh(1, "R3", 1, 0, 0, 0, 0);
    strobe();
    chkCh(1, "R6", 0, 0, 3, 1, 2);
  endtask

  task automatic tChannelSelect();
    sendWord(mkWord(6'd49, 1'b1, 3'b101, 2'b11, 2'b01));
    strobe();
    chkCh(2, "R4", 0, 48, 5, 3, 1);
    chkCh(1, "R4", 0, 0, 3, 1, 2);
  endtask

  task automatic tGainSweep();
    for (int c = 0; c < 64; c++) begin
      sendWord(mkWord(6'(c), 1'b0, 3'b000, 2'b00, 2'b00));
      strobe();
      if (c == 0)       chk("R5", "code0 mute", int'(ch1Mute), 1);
      else if (c <= 49) chk("R6", "mid mute", int'(ch1Mute), 0);
      else              chk("R7", "top mute", int'(ch1Mute), 0);
      chk(c > 49 ? "R7" : (c == 0 ? "R5" : "R6"), "dB", int'(ch1GainDb), expDb(c));
    end
    chkCh(2, "R4", 0, 48, 5, 3, 1);
  endtask

  task automatic tFields();
    for (int m = 0; m < 8; m++) begin
      sendWord(mkWord(6'd1, 1'b1, 3'(m), 2'(m % 4), 2'(3 - (m % 4))));
      strobe();
      chk("R8", "ch2 mask", int'(ch2InMask), m);
      chk("R9", "ch2 modeA", int'(ch2ModeA), m % 4);
      chk("R9", "ch2 modeB", int'(ch2ModeB), 3 - (m % 4));
      chk("R6", "ch2 dB floor", int'(ch2GainDb), -48);
    end
  endtask

  task automatic tExcessBits();
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    sendWord(mkWord(6'd30, 1'b0, 3'b100, 2'b10, 2'b11));
    strobe();
    chkCh(1, "R2", 0, 10, 4, 2, 3);
    // MSB-first order: bit-reversed word would give a different channel and code
    sendWord(mkWord(6'd2, 1'b1, 3'b010, 2'b00, 2'b01));
    strobe();
    chkCh(2, "R2", 0, -46, 2, 0, 1);
    chkCh(1, "R4", 0, 10, 4, 2, 3);
  endtask

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    tReset();
    tShiftOnly();
    tChannelSelect();
    tGainSweep();
    tFields();
    tExcessBits();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule